// File: doc/BRIEF.md
# Machine Timer with Compare Interrupt

This block keeps a 64-bit machine time value and a 64-bit compare threshold, each stored as two 32-bit halves. The surrounding logic pulses an update strobe together with an elapsed-time amount. On that strobe the amount is added to the time value, and the block then decides whether the timer interrupt is pending. The pending flag is registered and is also placed at its fixed position in a 32-bit interrupt-pending vector.

The block also holds a sleep flag for a hart that is waiting for an interrupt. The hart raises a request to set this flag. The first update on which the interrupt condition holds clears the flag and emits a one-cycle wake pulse. Software reaches all four halves through one 32-bit write-data bus that has a separate write enable per half, plus a 2-bit read select. Address decoding, interrupt enable masking and trap entry are handled elsewhere.

Top module: `mtimer_cmp`

## Requirements
- R1: Reset (rst_n low) clears the time value, the compare value, the pending flag, the sleep flag and the wake pulse.
- R2: On a tick_i cycle with neither time write enable set, the time low half takes (low + elapsed_i) mod 2^32, and the high half goes up by one exactly when that low addition wraps. The full 64-bit value wraps to zero past all-ones.
- R3: Every tick_i recomputes pending_o from the time and compare values as they stand after that cycle. pending_o is 1 only when time is strictly greater than compare: either the high half is greater, or the high halves are equal and the low half is greater. The result is visible from the clock edge that takes the tick.
- R4: If the whole 64-bit compare value is zero after a tick_i cycle, pending_o is 0 whatever the time value holds. A zero high half alone does not disable the interrupt.
- R5: pending_o is not sticky. A tick_i whose condition is false clears it. Between ticks it holds its value, even when a register write changes the condition.
- R6: sleep_req_i sets the sleep flag (sleeping_o). A tick_i whose pending condition is true clears the flag, and clear wins over a request in the same cycle. If the flag was set or being requested, that tick also drives wake_o high for exactly one cycle. A tick with a false condition leaves the flag as it is.
- R7: irq_pend_o carries pending_o at bit 7, and all its other bits are 0.
- R8: wr_time_lo_i, wr_time_hi_i, wr_cmp_lo_i and wr_cmp_hi_i each load wdata_i into one half at the next edge. rd_sel_i chooses the read-back half on rdata_o with the encoding 0 = time low, 1 = time high, 2 = compare low, 3 = compare high.
- R9: When a time write enable is set in a tick_i cycle, the written half takes wdata_i, the elapsed addition is dropped for both halves that cycle, and the pending decision uses the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Update strobe: add elapsed time and re-evaluate the interrupt |
| elapsed_i | input | 32 | Amount to add to the time value on tick_i |
| wdata_i | input | 32 | Register write data |
| wr_time_lo_i | input | 1 | Write enable, time low half |
| wr_time_hi_i | input | 1 | Write enable, time high half |
| wr_cmp_lo_i | input | 1 | Write enable, compare low half |
| wr_cmp_hi_i | input | 1 | Write enable, compare high half |
| rd_sel_i | input | 2 | Read-back half select |
| sleep_req_i | input | 1 | Hart enters wait-for-interrupt sleep |
| rdata_o | output | 32 | Selected half |
| pending_o | output | 1 | Timer interrupt pending |
| irq_pend_o | output | 32 | Interrupt-pending vector with the timer bit at position 7 |
| sleeping_o | output | 1 | Sleep flag |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The hardest cases to reach are the ones where the carry out of the low half decides the outcome. In one, the time value becomes exactly equal to the compare value only because of that carry. In another, the high halves differ in one direction while the low halves differ in the other. Software cannot simply wait for these states, so the bench preloads both 64-bit values through the write enables and then applies one tick with a chosen elapsed amount that lands each case precisely. The bench also places a time write inside a tick cycle, and separately changes the compare value between ticks, to show that the addition is dropped in the first case and that the flag is held in the second.

// File: rtl/mtimer_pkg.sv
// Package: shared constants and the read-select encoding for the machine timer.
// Assumes 32-bit register halves on the software side.
package mtimer_pkg;
    localparam int MT_HALF_W   = 32;
    localparam int MT_VEC_W    = 32;
    localparam int MT_PEND_BIT = 7;

    typedef enum logic [1:0] {
        SEL_TIME_LO = 2'd0,
        SEL_TIME_HI = 2'd1,
        SEL_CMP_LO  = 2'd2,
        SEL_CMP_HI  = 2'd3
    } mt_sel_e;
endpackage

// File: rtl/mtimer_counter.sv
// Module: two-half time counter. On tick it adds the elapsed amount to the
// low half and carries into the high half. A write to either half wins over
// the addition, which is then dropped for that cycle.
// Assumes: write enables and tick are synchronous to clk.
module mtimer_counter #(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [HALF_W-1:0] elapsed_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [HALF_W-1:0] wdata_i,
    output logic [HALF_W-1:0] lo_o,
    output logic [HALF_W-1:0] hi_o,
    output logic [HALF_W-1:0] nxt_lo_o,
    output logic [HALF_W-1:0] nxt_hi_o
);
    localparam int SUM_W = HALF_W + 1;

    logic [HALF_W-1:0] lo_q, hi_q;
    logic [SUM_W-1:0]  lo_sum;
    logic              carry;
    logic              advance;

    // Low-half addition with its carry out.
    always_comb begin
        lo_sum  = {1'b0, lo_q} + {1'b0, elapsed_i};
        carry   = lo_sum[HALF_W];
        advance = tick_i && !wr_lo_i && !wr_hi_i;
    end

    // Next-state selection: write, then advance, then hold.
    always_comb begin
        if (wr_lo_i)      nxt_lo_o = wdata_i;
        else if (advance) nxt_lo_o = lo_sum[HALF_W-1:0];
        else              nxt_lo_o = lo_q;

        if (wr_hi_i)      nxt_hi_o = wdata_i;
        else if (advance) nxt_hi_o = hi_q + {{(HALF_W-1){1'b0}}, carry};
        else              nxt_hi_o = hi_q;
    end

    // Time registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= nxt_lo_o;
            hi_q <= nxt_hi_o;
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;
endmodule

// File: rtl/mtimer_cmpreg.sv
// Module: compare threshold, one register per half, each loaded by its own
// write enable. It also exposes the value in effect after this cycle.
// Assumes: index 0 is the low half, index 1 the high half.
module mtimer_cmpreg #(
    parameter int HALF_W = 32,
    parameter int NHALF  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NHALF-1:0]        wr_i,
    input  logic [HALF_W-1:0]       wdata_i,
    output logic [NHALF*HALF_W-1:0] q_o,
    output logic [NHALF*HALF_W-1:0] nxt_o
);
    genvar h;
    generate
        for (h = 0; h < NHALF; h++) begin : g_half
            logic [HALF_W-1:0] half_q;

            // Next value of this half: written data or hold.
            always_comb nxt_o[h*HALF_W +: HALF_W] = wr_i[h] ? wdata_i : half_q;

            // Half register.
            always_ff @(posedge clk) begin
                if (!rst_n) half_q <= '0;
                else        half_q <= nxt_o[h*HALF_W +: HALF_W];
            end

            assign q_o[h*HALF_W +: HALF_W] = half_q;
        end
    endgenerate
endmodule

// File: rtl/mtimer_compare.sv
// Module: combinational strict greater-than between two split 64-bit values,
// qualified by a non-zero compare value.
// Assumes: both inputs reflect the state after the current cycle.
module mtimer_compare #(
    parameter int HALF_W = 32
) (
    input  logic [HALF_W-1:0] time_lo_i,
    input  logic [HALF_W-1:0] time_hi_i,
    input  logic [HALF_W-1:0] cmp_lo_i,
    input  logic [HALF_W-1:0] cmp_hi_i,
    output logic              fire_o
);
    logic hi_gt, hi_eq, lo_gt, cmp_zero;

    // Half-wise relations combined into the 64-bit decision.
    always_comb begin
        hi_gt    = time_hi_i > cmp_hi_i;
        hi_eq    = time_hi_i == cmp_hi_i;
        lo_gt    = time_lo_i > cmp_lo_i;
        cmp_zero = (cmp_hi_i == '0) && (cmp_lo_i == '0);
        fire_o   = (hi_gt || (hi_eq && lo_gt)) && !cmp_zero;
    end
endmodule

// File: rtl/mtimer_irq.sv
// Module: pending flag, sleep flag and wake pulse. Pending is re-evaluated
// only on tick. A firing tick clears sleep, and clear wins over a request.
// Assumes: fire_i is already computed from post-update values.
module mtimer_irq #(
    parameter int VEC_W    = 32,
    parameter int PEND_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             fire_i,
    input  logic             sleep_req_i,
    output logic             pending_o,
    output logic             sleeping_o,
    output logic             wake_o,
    output logic [VEC_W-1:0] vec_o
);
    logic pend_q, sleep_q, wake_q;
    logic fire_now;

    // A tick whose condition holds.
    always_comb fire_now = tick_i && fire_i;

    // Pending: recomputed on tick, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (tick_i) pend_q <= fire_i;
    end

    // Sleep flag: clear on firing tick, else set on request.
    always_ff @(posedge clk) begin
        if (!rst_n)           sleep_q <= 1'b0;
        else if (fire_now)    sleep_q <= 1'b0;
        else if (sleep_req_i) sleep_q <= 1'b1;
    end

    // Wake pulse: one cycle when a firing tick ends a sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= fire_now && (sleep_q || sleep_req_i);
    end

    genvar b;
    generate
        for (b = 0; b < VEC_W; b++) begin : g_vec
            if (b == PEND_BIT) begin : g_pend
                assign vec_o[b] = pend_q;
            end else begin : g_zero
                assign vec_o[b] = 1'b0;
            end
        end
    endgenerate

    assign pending_o  = pend_q;
    assign sleeping_o = sleep_q;
    assign wake_o     = wake_q;
endmodule

// File: rtl/mtimer_cmp.sv
// Module: machine timer top. It ties together the time counter, the compare
// register, the greater-than logic and the interrupt/sleep state, and
// provides the read-back mux.
// Assumes: one software write per half per cycle, shared write data.
module mtimer_cmp #(
    parameter int HALF_W   = mtimer_pkg::MT_HALF_W,
    parameter int VEC_W    = mtimer_pkg::MT_VEC_W,
    parameter int PEND_BIT = mtimer_pkg::MT_PEND_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [HALF_W-1:0] elapsed_i,
    input  logic [HALF_W-1:0] wdata_i,
    input  logic              wr_time_lo_i,
    input  logic              wr_time_hi_i,
    input  logic              wr_cmp_lo_i,
    input  logic              wr_cmp_hi_i,
    input  logic [1:0]        rd_sel_i,
    input  logic              sleep_req_i,
    output logic [HALF_W-1:0] rdata_o,
    output logic              pending_o,
    output logic [VEC_W-1:0]  irq_pend_o,
    output logic              sleeping_o,
    output logic              wake_o
);
    import mtimer_pkg::*;

    localparam int NHALF = 2;

    logic [HALF_W-1:0]       time_lo, time_hi, nxt_time_lo, nxt_time_hi;
    logic [NHALF*HALF_W-1:0] cmp_q, cmp_nxt;
    logic [HALF_W-1:0]       cmp_lo, cmp_hi;
    logic                    fire;
    mt_sel_e                 sel;

    mtimer_counter #(.HALF_W(HALF_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .elapsed_i(elapsed_i),
        .wr_lo_i  (wr_time_lo_i),
        .wr_hi_i  (wr_time_hi_i),
        .wdata_i  (wdata_i),
        .lo_o     (time_lo),
        .hi_o     (time_hi),
        .nxt_lo_o (nxt_time_lo),
        .nxt_hi_o (nxt_time_hi)
    );

    mtimer_cmpreg #(.HALF_W(HALF_W), .NHALF(NHALF)) u_cmpr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   ({wr_cmp_hi_i, wr_cmp_lo_i}),
        .wdata_i(wdata_i),
        .q_o    (cmp_q),
        .nxt_o  (cmp_nxt)
    );

    assign cmp_lo = cmp_q[HALF_W-1:0];
    assign cmp_hi = cmp_q[2*HALF_W-1:HALF_W];

    mtimer_compare #(.HALF_W(HALF_W)) u_gt (
        .time_lo_i(nxt_time_lo),
        .time_hi_i(nxt_time_hi),
        .cmp_lo_i (cmp_nxt[HALF_W-1:0]),
        .cmp_hi_i (cmp_nxt[2*HALF_W-1:HALF_W]),
        .fire_o   (fire)
    );

    mtimer_irq #(.VEC_W(VEC_W), .PEND_BIT(PEND_BIT)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .fire_i     (fire),
        .sleep_req_i(sleep_req_i),
        .pending_o  (pending_o),
        .sleeping_o (sleeping_o),
        .wake_o     (wake_o),
        .vec_o      (irq_pend_o)
    );

    // Read-back mux over the four halves.
    always_comb begin
        sel = mt_sel_e'(rd_sel_i);
        case (sel)
            SEL_TIME_LO: rdata_o = time_lo;
            SEL_TIME_HI: rdata_o = time_hi;
            SEL_CMP_LO:  rdata_o = cmp_lo;
            default:     rdata_o = cmp_hi;
        endcase
    end
endmodule

// File: rtl/mtimer_cmp_chk.sv
// Checker: temporal properties of the machine timer, bound to the top.
// Assumes: synchronous active-low reset.
module mtimer_cmp_chk #(
    parameter int HALF_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic [HALF_W-1:0] elapsed_i,
    input logic [HALF_W-1:0] wdata_i,
    input logic              wr_time_lo_i,
    input logic              wr_time_hi_i,
    input logic              wr_cmp_lo_i,
    input logic              wr_cmp_hi_i,
    input logic [HALF_W-1:0] time_lo,
    input logic [HALF_W-1:0] time_hi,
    input logic [HALF_W-1:0] cmp_lo,
    input logic [HALF_W-1:0] cmp_hi,
    input logic              pending_o,
    input logic              sleeping_o,
    input logic              wake_o
);
    p_lo_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_time_lo_i && !wr_time_hi_i)
        |=> time_lo == $past(time_lo + elapsed_i));

    p_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_time_lo_i && !wr_time_hi_i && (time_lo > ~elapsed_i))
        |=> time_hi == $past(time_hi + 1'b1));

    p_zero_cmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_cmp_lo_i && !wr_cmp_hi_i && cmp_lo == '0 && cmp_hi == '0)
        |=> !pending_o);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(pending_o));

    p_wake_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (!sleeping_o && pending_o));

    p_wake_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(tick_i));

    p_cmp_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmp_lo_i |=> cmp_lo == $past(wdata_i));
endmodule

bind mtimer_cmp mtimer_cmp_chk #(.HALF_W(HALF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .elapsed_i   (elapsed_i),
    .wdata_i     (wdata_i),
    .wr_time_lo_i(wr_time_lo_i),
    .wr_time_hi_i(wr_time_hi_i),
    .wr_cmp_lo_i (wr_cmp_lo_i),
    .wr_cmp_hi_i (wr_cmp_hi_i),
    .time_lo     (time_lo),
    .time_hi     (time_hi),
    .cmp_lo      (cmp_lo),
    .cmp_hi      (cmp_hi),
    .pending_o   (pending_o),
    .sleeping_o  (sleeping_o),
    .wake_o      (wake_o)
);

// File: tb/mtimer_cmp_tb.sv
`timescale 1ns/1ps
module mtimer_cmp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [31:0] elapsed_i = '0;
    logic [31:0] wdata_i = '0;
    logic        wr_time_lo_i = 1'b0, wr_time_hi_i = 1'b0;
    logic        wr_cmp_lo_i = 1'b0, wr_cmp_hi_i = 1'b0;
    logic [1:0]  rd_sel_i = '0;
    logic        sleep_req_i = 1'b0;
    logic [31:0] rdata_o;
    logic        pending_o;
    logic [31:0] irq_pend_o;
    logic        sleeping_o;
    logic        wake_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    mtimer_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .elapsed_i(elapsed_i),
        .wdata_i(wdata_i), .wr_time_lo_i(wr_time_lo_i), .wr_time_hi_i(wr_time_hi_i),
        .wr_cmp_lo_i(wr_cmp_lo_i), .wr_cmp_hi_i(wr_cmp_hi_i), .rd_sel_i(rd_sel_i),
        .sleep_req_i(sleep_req_i), .rdata_o(rdata_o), .pending_o(pending_o),
        .irq_pend_o(irq_pend_o), .sleeping_o(sleeping_o), .wake_o(wake_o)
    );

    // Vector table: compare, starting time, elapsed, expected pending.
    localparam int NV = 9;
    localparam logic [63:0] V_CMP [NV] = '{
        64'h0000_0000_0000_0010, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0000,
        64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 64'h0000_0001_FFFF_FFFF,
        64'h0000_0002_0000_0000, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001};
    localparam logic [63:0] V_TIME [NV] = '{
        64'h0000_0000_0000_000F, 64'h0000_0000_0000_000F, 64'hFFFF_FFFF_FFFF_FF00,
        64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 64'h0000_0002_0000_0000,
        64'h0000_0001_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000};
    localparam logic [31:0] V_EL [NV] = '{
        32'd1, 32'd2, 32'd5, 32'd1, 32'd2, 32'd0, 32'd5, 32'd1, 32'd2};
    localparam logic V_PEND [NV] = '{
        1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Entered at a negedge; applies one clock of stimulus, returns at next negedge.
    task automatic step_cycle();
        @(negedge clk);
        tick_i = 1'b0; wr_time_lo_i = 1'b0; wr_time_hi_i = 1'b0;
        wr_cmp_lo_i = 1'b0; wr_cmp_hi_i = 1'b0; sleep_req_i = 1'b0;
    endtask

    task automatic wr_half(input int sel, input logic [31:0] d);
        wdata_i = d;
        case (sel)
            0: wr_time_lo_i = 1'b1;
            1: wr_time_hi_i = 1'b1;
            2: wr_cmp_lo_i  = 1'b1;
            default: wr_cmp_hi_i = 1'b1;
        endcase
        step_cycle();
    endtask

    task automatic do_tick(input logic [31:0] el);
        tick_i = 1'b1; elapsed_i = el;
        step_cycle();
    endtask

    task automatic rd_half(input logic [1:0] sel, output logic [31:0] v);
        rd_sel_i = sel; #0.5; v = rdata_o;
    endtask

    task automatic rd_time(output logic [63:0] t);
        logic [31:0] lo, hi;
        rd_half(2'd0, lo); rd_half(2'd1, hi);
        t = {hi, lo};
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] t;
        logic [31:0] v;
        @(negedge clk); @(negedge clk);
        // R1: reset state
        check("R1 pending", {63'd0, pending_o}, 64'd0);
        check("R1 sleeping", {63'd0, sleeping_o}, 64'd0);
        check("R1 wake", {63'd0, wake_o}, 64'd0);
        rd_time(t); check("R1 time", t, 64'd0);
        rd_half(2'd2, v); check("R1 cmp lo", {32'd0, v}, 64'd0);
        rd_half(2'd3, v); check("R1 cmp hi", {32'd0, v}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 addition/carry, R3 strict compare, R4 zero compare, R8 writes
        for (int i = 0; i < NV; i++) begin
            wr_half(0, V_TIME[i][31:0]);
            wr_half(1, V_TIME[i][63:32]);
            wr_half(2, V_CMP[i][31:0]);
            wr_half(3, V_CMP[i][63:32]);
            rd_half(2'd2, v); check("R8 cmp lo readback", {32'd0, v}, {32'd0, V_CMP[i][31:0]});
            rd_half(2'd3, v); check("R8 cmp hi readback", {32'd0, v}, {32'd0, V_CMP[i][63:32]});
            do_tick(V_EL[i]);
            rd_time(t); check("R2 time after tick", t, V_TIME[i] + {32'd0, V_EL[i]});
            check("R3/R4 pending", {63'd0, pending_o}, {63'd0, V_PEND[i]});
        end

        // R5/R6/R7 directed
        wr_half(0, 32'h0); wr_half(1, 32'h0);
        wr_half(2, 32'h100); wr_half(3, 32'h0);
        do_tick(32'h0);
        check("R5 pending cleared", {63'd0, pending_o}, 64'd0);
        check("R7 vector idle", {32'd0, irq_pend_o}, 64'd0);
        sleep_req_i = 1'b1; step_cycle();
        check("R6 sleep set", {63'd0, sleeping_o}, 64'd1);
        do_tick(32'h50);
        check("R6 sleep kept on false tick", {63'd0, sleeping_o}, 64'd1);
        check("R6 no wake on false tick", {63'd0, wake_o}, 64'd0);
        do_tick(32'hC0);
        check("R6 wake pulse", {63'd0, wake_o}, 64'd1);
        check("R6 sleep cleared", {63'd0, sleeping_o}, 64'd0);
        check("R3 pending at 0x110>0x100", {63'd0, pending_o}, 64'd1);
        check("R7 vector bit7", {32'd0, irq_pend_o}, 64'h80);
        step_cycle();
        check("R6 wake one cycle", {63'd0, wake_o}, 64'd0);
        wr_half(3, 32'h1);
        step_cycle();
        check("R5 pending held between ticks", {63'd0, pending_o}, 64'd1);
        do_tick(32'h0);
        check("R5 pending cleared by false tick", {63'd0, pending_o}, 64'd0);

        // R6: fire with request in same cycle, clear wins
        wr_half(3, 32'h0);
        sleep_req_i = 1'b1; do_tick(32'h0);
        check("R6 clear beats request", {63'd0, sleeping_o}, 64'd0);
        check("R6 wake with request", {63'd0, wake_o}, 64'd1);
        wr_half(3, 32'h1);

        // R9: time write during tick drops the addition
        tick_i = 1'b1; elapsed_i = 32'd5; wr_half(0, 32'h7);
        rd_time(t); check("R9 lo write wins", t, 64'h0000_0000_0000_0007);
        tick_i = 1'b1; elapsed_i = 32'd1; wr_half(1, 32'h2);
        rd_time(t); check("R9 hi write, no add", t, 64'h0000_0002_0000_0007);
        check("R9 pending uses written value", {63'd0, pending_o}, 64'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule